// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Less-Than

This block is a purely combinational integer arithmetic-logic unit for a processor execute stage. Two operands and a 3-bit operation code go in. A result word and three flags come out within the same cycle.

The datapath is one 1-bit slice repeated across the word. Each slice has an AND path, an OR path, a full adder with a conditional inversion of its B input, and an output selector. A small decoder turns the operation code into a bundle of strobes that every slice shares: invert-B, adder carry-in, output select, and flag enable.

Subtraction adds the inverted B operand with a carry-in of one. Signed less-than performs that same subtraction. It then takes the sign of the difference, corrected for overflow, and routes it back from the top slice into the "less" input of slice zero. The "less" inputs of all other slices are tied to zero. The zero flag lets a caller test two operands for equality by subtracting them.

Top module: `alu_bitslice`

## Requirements
- R1: Operation code 3'b000 yields the bitwise AND of the two operands.
- R2: Operation code 3'b001 yields the bitwise OR of the two operands.
- R3: Operation code 3'b010 yields the sum modulo 2^WIDTH. `carryOut` equals the carry leaving the top bit.
- R4: Operation code 3'b110 yields opA minus opB modulo 2^WIDTH, formed as opA + ~opB + 1. `carryOut` is 1 exactly when opA >= opB, comparing both as unsigned numbers.
- R5: Operation code 3'b111 places 1 in bit 0 when opA < opB as two's-complement signed numbers, and 0 otherwise. All higher bits are 0. The comparison is correct even when the internal subtraction overflows.
- R6: `isZero` is 1 exactly when every bit of `result` is 0, for every operation code.
- R7: `overflow` is 1 for add and subtract exactly when the signed result does not fit in WIDTH bits. It is 0 for every other operation code.
- R8: The operation codes 3'b011, 3'b100 and 3'b101 yield an all-zero result with `overflow` and `carryOut` both 0.
- R9: `carryOut` is 0 for AND, OR and less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH (32) | First operand |
| opB | input | WIDTH (32) | Second operand |
| opCode | input | 3 | Operation select |
| result | output | WIDTH (32) | Selected result word |
| isZero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carryOut | output | 1 | Carry from the top bit for add or subtract |

## Verification
Less-than is driven with operand pairs whose difference overflows, namely the most negative value against the most positive and the reverse. A design that used the raw sign of the difference would invert the answer in exactly those cases. Subtraction is run with a borrow and with equal operands. A missing carry-in of one shows up as an off-by-one difference and a wrong `carryOut`, and a broken zero flag shows up in the equal-operand case. The unused operation codes and the flag gating are checked with all-ones operands. Any leak from the adder or the logic paths would then appear as nonzero result bits or as stray `overflow` or `carryOut`.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [2:0] CODE_AND = 3'b000;
  localparam logic [2:0] CODE_OR  = 3'b001;
  localparam logic [2:0] CODE_ADD = 3'b010;
  localparam logic [2:0] CODE_SUB = 3'b110;
  localparam logic [2:0] CODE_SLT = 3'b111;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_AND  = 3'd1,
    SEL_OR   = 3'd2,
    SEL_SUM  = 3'd3,
    SEL_LESS = 3'd4
  } sel_e;

  typedef struct packed {
    logic invertB;
    logic carryIn;
    sel_e sel;
    logic arithFlags;
  } strobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] opCode,
  output strobe_t    strobe
);

  always_comb begin
    strobe = '{invertB: 1'b0, carryIn: 1'b0, sel: SEL_NONE, arithFlags: 1'b0};
    case (opCode)
      CODE_AND: strobe.sel = SEL_AND;
      CODE_OR:  strobe.sel = SEL_OR;
      CODE_ADD: begin
        strobe.sel        = SEL_SUM;
        strobe.arithFlags = 1'b1;
      end
      CODE_SUB: begin
        strobe.sel        = SEL_SUM;
        strobe.invertB    = 1'b1;
        strobe.carryIn    = 1'b1;
        strobe.arithFlags = 1'b1;
      end
      CODE_SLT: begin
        strobe.sel     = SEL_LESS;
        strobe.invertB = 1'b1;
        strobe.carryIn = 1'b1;
      end
      default: ;
    endcase
  end

  // R4: a subtracting code must both invert B and inject a carry of one
  always_comb begin
    p_sub_inject_r4: assert (strobe.invertB == strobe.carryIn)
      else $error("invert-B and carry-in strobes disagree");
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic aBit,
  input  logic bBit,
  input  logic lessIn,
  input  logic carryIn,
  input  logic invertB,
  input  sel_e sel,
  output logic resBit,
  output logic sumBit,
  output logic carryOut
);

  logic bEff;

  always_comb begin
    bEff     = bBit ^ invertB;
    sumBit   = aBit ^ bEff ^ carryIn;
    carryOut = (aBit & bEff) | (carryIn & (aBit ^ bEff));
    case (sel)
      SEL_AND:  resBit = aBit & bBit;
      SEL_OR:   resBit = aBit | bBit;
      SEL_SUM:  resBit = sumBit;
      SEL_LESS: resBit = lessIn;
      default:  resBit = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobe_t          strobe,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             overflow,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum;
  logic             ovfRaw;
  logic             setSign;

  assign carry[0] = strobe.carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lessBit;
    if (i == 0) begin : g_lsb
      assign lessBit = setSign;
    end else begin : g_upper
      assign lessBit = 1'b0;
    end
    alu_slice u_slice (
      .aBit    (opA[i]),
      .bBit    (opB[i]),
      .lessIn  (lessBit),
      .carryIn (carry[i]),
      .invertB (strobe.invertB),
      .sel     (strobe.sel),
      .resBit  (result[i]),
      .sumBit  (sum[i]),
      .carryOut(carry[i+1])
    );
  end

  always_comb begin
    ovfRaw   = carry[WIDTH] ^ carry[MSB];
    setSign  = sum[MSB] ^ ovfRaw;
    isZero   = ~|result;
    overflow = strobe.arithFlags & ovfRaw;
    carryOut = strobe.arithFlags & carry[WIDTH];
  end

  // R3, R4: the slice ripple must agree with a word-level sum
  always_comb begin
    p_ripple_sum_r3: assert (sum == (opA + (opB ^ {WIDTH{strobe.invertB}})
                                     + {{(WIDTH-1){1'b0}}, strobe.carryIn}))
      else $error("ripple sum mismatch");
  end

  // R5: the less-than result uses bit 0 only
  always_comb begin
    p_slt_upper_r5: assert (strobe.sel != SEL_LESS || result[MSB:1] == '0)
      else $error("less-than set upper bits");
  end

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       opCode,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             overflow,
  output logic             carryOut
);

  strobe_t strobe;

  alu_ctrl u_ctrl (
    .opCode(opCode),
    .strobe(strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .isZero  (isZero),
    .overflow(overflow),
    .carryOut(carryOut)
  );

  // R5: signed comparison outcome in bit 0
  always_comb begin
    p_slt_signed_r5: assert (opCode != CODE_SLT ||
                             result[0] == ($signed(opA) < $signed(opB)))
      else $error("signed less-than wrong");
  end

  // R6: zero after subtract means equal operands
  always_comb begin
    p_eq_zero_r6: assert (opCode != CODE_SUB || isZero == (opA == opB))
      else $error("zero flag does not reflect equality");
  end

  // R8: unused codes give zeros and no flags
  always_comb begin
    p_unused_quiet_r8: assert (!(opCode inside {3'b011, 3'b100, 3'b101}) ||
                               (result == '0 && !overflow && !carryOut))
      else $error("unused code produced output");
  end

  // R7, R9: no arithmetic flags on logic or less-than codes
  always_comb begin
    p_no_flags_r9: assert (!(opCode inside {CODE_AND, CODE_OR, CODE_SLT}) ||
                           (!overflow && !carryOut))
      else $error("flags raised on non-arithmetic code");
  end

endmodule

// File: tb/alu_bitslice_tb.sv
module alu_bitslice_tb;

  localparam int W = 32;
  localparam int NVEC = 14;

  // {code, a, b, expected result}
  localparam logic [98:0] VEC [NVEC] = '{
    {3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000},
    {3'b001, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'hFFFFFFFF},
    {3'b010, 32'h00000005, 32'h00000007, 32'h0000000C},
    {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    {3'b110, 32'h00000009, 32'h00000003, 32'h00000006},
    {3'b110, 32'h00000003, 32'h00000009, 32'hFFFFFFFA},
    {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},
    {3'b111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    {3'b111, 32'h00000001, 32'hFFFFFFFF, 32'h00000000},
    {3'b111, 32'h80000000, 32'h7FFFFFFF, 32'h00000001},
    {3'b111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000},
    {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000},
    {3'b110, 32'h12345678, 32'h12345678, 32'h00000000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   opCode = 3'b000;
  logic [W-1:0] result;
  logic isZero, overflow, carryOut;

  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  alu_bitslice #(.WIDTH(W)) u_dut (
    .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .isZero(isZero), .overflow(overflow), .carryOut(carryOut)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected flags {zero, overflow, carry} from the requirements
  function automatic logic [2:0] model_flags(input logic [2:0] c, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic [W-1:0] r);
    logic z, v, k;
    logic [W:0] wide;
    z = (r == '0);
    v = 1'b0;
    k = 1'b0;
    if (c == 3'b010) begin
      wide = {1'b0, a} + {1'b0, b};
      k = wide[W];
      v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
    end else if (c == 3'b110) begin
      k = (a >= b);
      v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
    end
    return {z, v, k};
  endfunction

  function automatic logic [W-1:0] model_res(input logic [2:0] c, input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    case (c)
      3'b000:  return a & b;
      3'b001:  return a | b;
      3'b010:  return a + b;
      3'b110:  return a - b;
      3'b111:  return {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction

  task automatic apply(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    opCode = c; opA = a; opB = b;
    @(negedge clk);
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b110:  return "R4";
      3'b111:  return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check_flags(input logic [2:0] c, input logic [W-1:0] a,
                             input logic [W-1:0] b, input logic [W-1:0] r);
    logic [2:0] f;
    f = model_flags(c, a, b, r);
    check("R6 isZero", {31'd0, isZero}, {31'd0, f[2]});
    check("R7 overflow", {31'd0, overflow}, {31'd0, f[1]});
    check("R9/R3/R4 carryOut", {31'd0, carryOut}, {31'd0, f[0]});
  endtask

  initial begin
    logic [W-1:0] lfsrA, lfsrB;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state: AND of zeros
    check("R1 reset result", result, '0);
    check("R6 reset isZero", {31'd0, isZero}, 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32]);
      check(req_of(VEC[i][98:96]), result, VEC[i][31:0]);
      check_flags(VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R8: every unused code, all-ones operands
    for (int k = 0; k < 3; k++) begin
      logic [2:0] c;
      c = (k == 0) ? 3'b011 : (k == 1) ? 3'b100 : 3'b101;
      apply(c, '1, '1);
      check("R8 result", result, '0);
      check("R8 overflow", {31'd0, overflow}, 32'd0);
      check("R8 carryOut", {31'd0, carryOut}, 32'd0);
    end

    // R5: equal operands are not less
    apply(3'b111, 32'h80000000, 32'h80000000);
    check("R5 equal", result, '0);
    // R9: no carry from AND/OR on all ones
    apply(3'b001, '1, '1);
    check("R9 OR carryOut", {31'd0, carryOut}, 32'd0);
    // R4: zero minus one borrows
    apply(3'b110, '0, 32'd1);
    check("R4 borrow result", result, '1);
    check("R4 borrow carryOut", {31'd0, carryOut}, 32'd0);

    // sweep over pseudo-random operands for every code
    lfsrA = 32'hACE11234;
    lfsrB = 32'h0BADF00D;
    for (int n = 0; n < 400; n++) begin
      logic [2:0] c;
      lfsrA = {lfsrA[30:0], lfsrA[31] ^ lfsrA[21] ^ lfsrA[1] ^ lfsrA[0]};
      lfsrB = {lfsrB[30:0], lfsrB[31] ^ lfsrB[21] ^ lfsrB[1] ^ lfsrB[0]};
      c = 3'(n % 8);
      apply(c, lfsrA, lfsrB);
      check(req_of(c), result, model_res(c, lfsrA, lfsrB));
      check_flags(c, lfsrA, lfsrB, model_res(c, lfsrA, lfsrB));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule